// File: doc/BRIEF.md
# Segment Privilege Check Unit

This unit judges one protection-sensitive request per clock: a data segment register load, a near or far control transfer without a gate, a transfer through a gate, an I/O-sensitive instruction, a privileged instruction, or a write of the I/O privilege field. The caller supplies the current privilege level, the requestor level taken from the selector, and the privilege and type bits of the referenced descriptor. For gate requests it also supplies the privilege and type bits of the descriptor that the gate targets, along with the I/O privilege field and a request code.

The unit computes an effective level, which is the larger numeric value of the requestor level and the current level. It checks the descriptor class against the rules for the request code. It then returns allow or deny, with exception vector 13 on a deny. For an allowed gate transfer it also returns the new current level and whether the interrupt flag must be cleared. The verdict passes through a parameterised register pipeline. Responses therefore come back in request order and a fixed number of cycles after the request.

Top module: `seg_priv_check`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `rsp_valid`, `rsp_allow`, `rsp_exc_valid`, `rsp_if_clear`, `rsp_exc_num` and `rsp_new_cpl` are all zero.
- R2: Each request with `req_valid` high gives exactly one response, exactly `PIPE_STAGES` clock edges later, in request order. Every response field is zero in cycles where `rsp_valid` is low.
- R3: Request code 1 (data load) is allowed only under three conditions. The descriptor must be a code/data descriptor (`desc_seg`=1). It must be either data (`desc_type[3]`=0) or readable code (`desc_type[3]`=1 and `desc_type[1]`=1). Its level must satisfy `desc_dpl` >= max(`cpl`,`rpl`).
- R4: Request code 4 (I/O-sensitive instruction) is allowed exactly when `cpl` <= `iopl`.
- R5: Request codes 5 (privileged instruction) and 6 (I/O privilege field write) are allowed exactly when `cpl` is 0.
- R6: Request code 0 (near transfer) is always allowed and leaves the level unchanged.
- R7: Request code 2 (far transfer, no gate) is allowed only for a code descriptor (`desc_seg`=1, `desc_type[3]`=1). If the code is nonconforming (`desc_type[2]`=0), it needs `desc_dpl` == `cpl`. If it is conforming, it needs `desc_dpl` <= `cpl`. `rsp_new_cpl` equals `cpl`.
- R8: Request code 3 (gate) needs a gate descriptor with `desc_seg`=0 and one of these types: call 4h or Ch, task 5h, interrupt 6h or Eh, trap 7h or Fh. Call, interrupt and trap gates must target code (`tgt_seg`=1, `tgt_type[3]`=1). A task gate must target a task state descriptor (`tgt_seg`=0, type 1h, 3h, 9h or Bh). Any other combination is denied.
- R9: A gate is denied unless `desc_dpl` >= max(`cpl`,`rpl`). A call, interrupt or trap gate also needs `tgt_dpl` <= `cpl`. When allowed, `rsp_new_cpl` is `tgt_dpl` for a nonconforming target and `cpl` for a conforming target or a task gate.
- R10: `rsp_if_clear` is 1 only for an allowed interrupt gate, and it is 0 for trap gates.
- R11: Every deny, including request code 7 (reserved), sets `rsp_exc_valid` with `rsp_exc_num` = 13 and gives `rsp_new_cpl` = `cpl`. Every allow gives `rsp_exc_valid`=0 and `rsp_exc_num`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Request code (0 near, 1 data load, 2 far, 3 gate, 4 I/O, 5 privileged, 6 I/O level write, 7 reserved) |
| cpl | input | 2 | Current privilege level |
| rpl | input | 2 | Requestor level from the selector |
| desc_dpl | input | 2 | Level of the referenced descriptor |
| desc_seg | input | 1 | Referenced descriptor is code/data (1) or system (0) |
| desc_type | input | 4 | Type bits of the referenced descriptor |
| tgt_dpl | input | 2 | Level of the gate's target descriptor |
| tgt_seg | input | 1 | Gate target is code/data (1) or system (0) |
| tgt_type | input | 4 | Type bits of the gate target |
| iopl | input | 2 | I/O privilege field |
| rsp_valid | output | 1 | Response present |
| rsp_allow | output | 1 | Request permitted |
| rsp_exc_valid | output | 1 | Exception raised |
| rsp_exc_num | output | 8 | Exception vector |
| rsp_new_cpl | output | 2 | Current level after the request |
| rsp_if_clear | output | 1 | Clear the interrupt flag |

## Verification
The bench builds the unit with `PIPE_STAGES` = 2 rather than the default of 1. This keeps two verdicts in flight at once, so back-to-back requests test ordering and the latency count against the queue. The gate-vector parameter stays at 13. The stimulus covers the edge levels 0 and 3 on every comparison: a requestor level that weakens an otherwise legal access, a conforming versus a nonconforming target, and each gate type pointed at a wrong target class.

// File: rtl/seg_priv_pkg.sv
`timescale 1ns/1ps
package seg_priv_pkg;

    localparam int PL_W  = 2;
    localparam int EXC_W = 8;
    localparam int TYP_W = 4;
    localparam int KND_W = 3;

    typedef logic [PL_W-1:0] plv_t;

    typedef enum logic [KND_W-1:0] {
        RK_NEAR    = 3'd0,
        RK_DATA    = 3'd1,
        RK_FAR     = 3'd2,
        RK_GATE    = 3'd3,
        RK_IO      = 3'd4,
        RK_PRIV    = 3'd5,
        RK_IOPL_WR = 3'd6,
        RK_RSVD    = 3'd7
    } req_kind_e;

    typedef enum logic [2:0] {
        GK_NONE = 3'd0,
        GK_CALL = 3'd1,
        GK_TASK = 3'd2,
        GK_INTR = 3'd3,
        GK_TRAP = 3'd4
    } gate_kind_e;

    typedef struct packed {
        logic       is_data;
        logic       is_code;
        logic       readable;
        logic       conforming;
        logic       is_tss;
        gate_kind_e gate;
    } desc_class_t;

    typedef struct packed {
        logic             allow;
        logic             exc_valid;
        logic [EXC_W-1:0] exc_num;
        plv_t             new_cpl;
        logic             if_clear;
    } verdict_t;

    // Numerically larger level is the less privileged one.
    function automatic plv_t pl_weaker(input plv_t a, input plv_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spc_desc_class.sv
`timescale 1ns/1ps
module spc_desc_class
    import seg_priv_pkg::*;
(
    input  logic             seg_bit,
    input  logic [TYP_W-1:0] type_bits,
    output desc_class_t      cls
);
    always_comb begin
        cls      = '0;
        cls.gate = GK_NONE;
        if (seg_bit) begin
            if (type_bits[3]) begin
                cls.is_code    = 1'b1;
                cls.conforming = type_bits[2];
                cls.readable   = type_bits[1];
            end else begin
                cls.is_data  = 1'b1;
                cls.readable = 1'b1;
            end
        end else begin
            unique case (type_bits)
                4'h1, 4'h3, 4'h9, 4'hB: cls.is_tss = 1'b1;
                4'h4, 4'hC:             cls.gate = GK_CALL;
                4'h5:                   cls.gate = GK_TASK;
                4'h6, 4'hE:             cls.gate = GK_INTR;
                4'h7, 4'hF:             cls.gate = GK_TRAP;
                default:                cls.gate = GK_NONE;
            endcase
        end
    end
endmodule

// File: rtl/spc_rule_eval.sv
`timescale 1ns/1ps
module spc_rule_eval
    import seg_priv_pkg::*;
#(
    parameter logic [EXC_W-1:0] GP_VECTOR = 8'd13
) (
    input  req_kind_e   kind,
    input  plv_t        cpl,
    input  plv_t        rpl,
    input  plv_t        iopl,
    input  plv_t        d_dpl,
    input  desc_class_t d_cls,
    input  plv_t        t_dpl,
    input  desc_class_t t_cls,
    output verdict_t    v
);
    plv_t epl;
    logic ok;
    logic gate_priv_ok;
    logic code_tgt_ok;
    plv_t nxt_cpl;
    logic clr_if;

    always_comb begin
        epl          = pl_weaker(rpl, cpl);
        gate_priv_ok = (d_dpl >= epl);
        code_tgt_ok  = t_cls.is_code && (t_dpl <= cpl);
        ok           = 1'b0;
        nxt_cpl      = cpl;
        clr_if       = 1'b0;
        unique case (kind)
            RK_NEAR: ok = 1'b1;
            RK_DATA: ok = d_cls.readable && (d_dpl >= epl);
            RK_FAR: begin
                if (d_cls.is_code)
                    ok = d_cls.conforming ? (d_dpl <= cpl) : (d_dpl == cpl);
            end
            RK_GATE: begin
                unique case (d_cls.gate)
                    GK_CALL, GK_INTR, GK_TRAP: begin
                        ok = gate_priv_ok && code_tgt_ok;
                        if (ok && !t_cls.conforming)
                            nxt_cpl = t_dpl;
                        clr_if = ok && (d_cls.gate == GK_INTR);
                    end
                    GK_TASK: ok = gate_priv_ok && t_cls.is_tss;
                    default: ok = 1'b0;
                endcase
            end
            RK_IO:               ok = (cpl <= iopl);
            RK_PRIV, RK_IOPL_WR: ok = (cpl == '0);
            default:             ok = 1'b0;
        endcase
        v.allow     = ok;
        v.exc_valid = !ok;
        v.exc_num   = ok ? '0 : GP_VECTOR;
        v.new_cpl   = nxt_cpl;
        v.if_clear  = clr_if;
    end
endmodule

// File: rtl/spc_pipe.sv
`timescale 1ns/1ps
module spc_pipe
    import seg_priv_pkg::*;
#(
    parameter int STAGES = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  verdict_t in_v,
    output logic     out_valid,
    output verdict_t out_v
);
    localparam int LAST = STAGES - 1;

    for (genvar g = 0; g < STAGES; g++) begin : stg
        logic     vld_q;
        verdict_t dat_q;
        logic     src_vld;
        verdict_t src_dat;
        if (g == 0) begin : head
            assign src_vld = in_valid;
            assign src_dat = in_v;
        end else begin : chain
            assign src_vld = stg[g-1].vld_q;
            assign src_dat = stg[g-1].dat_q;
        end
        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q <= 1'b0;
                dat_q <= '0;
            end else begin
                vld_q <= src_vld;
                dat_q <= src_vld ? src_dat : '0;
            end
        end
    end

    assign out_valid = stg[LAST].vld_q;
    assign out_v     = stg[LAST].dat_q;
endmodule

// File: rtl/seg_priv_check.sv
`timescale 1ns/1ps
module seg_priv_check
    import seg_priv_pkg::*;
#(
    parameter int               PIPE_STAGES = 1,
    parameter logic [EXC_W-1:0] GP_VECTOR   = 8'd13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [KND_W-1:0] req_kind,
    input  logic [PL_W-1:0]  cpl,
    input  logic [PL_W-1:0]  rpl,
    input  logic [PL_W-1:0]  desc_dpl,
    input  logic             desc_seg,
    input  logic [TYP_W-1:0] desc_type,
    input  logic [PL_W-1:0]  tgt_dpl,
    input  logic             tgt_seg,
    input  logic [TYP_W-1:0] tgt_type,
    input  logic [PL_W-1:0]  iopl,
    output logic             rsp_valid,
    output logic             rsp_allow,
    output logic             rsp_exc_valid,
    output logic [EXC_W-1:0] rsp_exc_num,
    output logic [PL_W-1:0]  rsp_new_cpl,
    output logic             rsp_if_clear
);
    desc_class_t d_cls;
    desc_class_t t_cls;
    verdict_t    dec_v;
    verdict_t    out_v;

    spc_desc_class u_dcls (.seg_bit(desc_seg), .type_bits(desc_type), .cls(d_cls));
    spc_desc_class u_tcls (.seg_bit(tgt_seg),  .type_bits(tgt_type),  .cls(t_cls));

    spc_rule_eval #(.GP_VECTOR(GP_VECTOR)) u_rules (
        .kind  (req_kind_e'(req_kind)),
        .cpl   (cpl),
        .rpl   (rpl),
        .iopl  (iopl),
        .d_dpl (desc_dpl),
        .d_cls (d_cls),
        .t_dpl (tgt_dpl),
        .t_cls (t_cls),
        .v     (dec_v)
    );

    spc_pipe #(.STAGES(PIPE_STAGES)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_v      (dec_v),
        .out_valid (rsp_valid),
        .out_v     (out_v)
    );

    assign rsp_allow     = out_v.allow;
    assign rsp_exc_valid = out_v.exc_valid;
    assign rsp_exc_num   = out_v.exc_num;
    assign rsp_new_cpl   = out_v.new_cpl;
    assign rsp_if_clear  = out_v.if_clear;
endmodule

// File: rtl/seg_priv_check_sva.sv
`timescale 1ns/1ps
module seg_priv_check_sva
    import seg_priv_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [KND_W-1:0] req_kind,
    input logic [PL_W-1:0]  cpl,
    input logic [PL_W-1:0]  rpl,
    input logic [PL_W-1:0]  desc_dpl,
    input logic [PL_W-1:0]  iopl,
    input verdict_t         dec_v,
    input logic             rsp_valid,
    input logic             rsp_allow,
    input logic             rsp_exc_valid,
    input logic [EXC_W-1:0] rsp_exc_num,
    input logic [PL_W-1:0]  rsp_new_cpl,
    input logic             rsp_if_clear
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !rsp_valid && !rsp_allow && !rsp_exc_valid && !rsp_if_clear); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !rsp_allow && !rsp_exc_valid && rsp_exc_num == '0
                       && rsp_new_cpl == '0 && !rsp_if_clear); // R2

    AST_DENY_RAISES_GP: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && !rsp_allow |-> rsp_exc_valid && rsp_exc_num == 8'd13); // R11

    AST_ALLOW_NO_EXC: assert property (@(posedge clk) disable iff (rst)
        rsp_valid && rsp_allow |-> !rsp_exc_valid && rsp_exc_num == '0); // R11

    AST_IFCLR_NEEDS_ALLOW: assert property (@(posedge clk) disable iff (rst)
        rsp_if_clear |-> rsp_valid && rsp_allow); // R10

    AST_IO_LEVEL: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == RK_IO && cpl > iopl |-> !dec_v.allow); // R4

    AST_PRIV_LEVEL0: assert property (@(posedge clk) disable iff (rst)
        req_valid && (req_kind == RK_PRIV || req_kind == RK_IOPL_WR) && cpl != '0
        |-> !dec_v.allow); // R5

    AST_DATA_RPL: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == RK_DATA && (desc_dpl < rpl || desc_dpl < cpl)
        |-> !dec_v.allow); // R3

    AST_NEAR_FREE: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_kind == RK_NEAR |-> dec_v.allow && dec_v.new_cpl == cpl); // R6
endmodule

bind seg_priv_check seg_priv_check_sva u_sva (.*);

// File: tb/test_seg_priv_check.sv
`timescale 1ns/1ps
module test_seg_priv_check;
    localparam int STAGES = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [2:0] req_kind = '0;
    logic [1:0] cpl = '0, rpl = '0, desc_dpl = '0, tgt_dpl = '0, iopl = '0;
    logic       desc_seg = 1'b0, tgt_seg = 1'b0;
    logic [3:0] desc_type = '0, tgt_type = '0;
    logic       rsp_valid, rsp_allow, rsp_exc_valid, rsp_if_clear;
    logic [7:0] rsp_exc_num;
    logic [1:0] rsp_new_cpl;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [12:0] exp_q[$];
    string       tag_q[$];
    int          cyc_q[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    seg_priv_check #(.PIPE_STAGES(STAGES)) i_seg_priv_check (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .cpl(cpl), .rpl(rpl), .desc_dpl(desc_dpl), .desc_seg(desc_seg),
        .desc_type(desc_type), .tgt_dpl(tgt_dpl), .tgt_seg(tgt_seg),
        .tgt_type(tgt_type), .iopl(iopl), .rsp_valid(rsp_valid),
        .rsp_allow(rsp_allow), .rsp_exc_valid(rsp_exc_valid),
        .rsp_exc_num(rsp_exc_num), .rsp_new_cpl(rsp_new_cpl),
        .rsp_if_clear(rsp_if_clear)
    );

    // Expected verdict packed as {allow, exc_valid, exc_num, new_cpl, if_clear}.
    function automatic logic [12:0] expect_of(
        input logic [2:0] k, input logic [1:0] c, input logic [1:0] r,
        input logic [1:0] dd, input logic ds, input logic [3:0] dt,
        input logic [1:0] td, input logic ts, input logic [3:0] tt,
        input logic [1:0] io);
        logic       ok = 1'b0;
        logic       ic = 1'b0;
        logic [1:0] nc = c;
        logic [1:0] eff = (r > c) ? r : c;
        logic is_call = !ds && (dt == 4'h4 || dt == 4'hC);
        logic is_task = !ds && dt == 4'h5;
        logic is_intr = !ds && (dt == 4'h6 || dt == 4'hE);
        logic is_trap = !ds && (dt == 4'h7 || dt == 4'hF);
        logic t_code  = ts && tt[3];
        logic t_tss   = !ts && (tt == 4'h1 || tt == 4'h3 || tt == 4'h9 || tt == 4'hB);
        if (k == 3'd0) ok = 1'b1;
        else if (k == 3'd1) ok = ds && (!dt[3] || dt[1]) && dd >= eff;
        else if (k == 3'd2) ok = ds && dt[3] && (dt[2] ? dd <= c : dd == c);
        else if (k == 3'd3) begin
            if (is_call || is_intr || is_trap) begin
                ok = (dd >= eff) && t_code && (td <= c);
                if (ok && !tt[2]) nc = td;
                ic = ok && is_intr;
            end else if (is_task) begin
                ok = (dd >= eff) && t_tss;
            end
        end
        else if (k == 3'd4) ok = (c <= io);
        else if (k == 3'd5 || k == 3'd6) ok = (c == 2'd0);
        return {ok, !ok, ok ? 8'd0 : 8'd13, nc, ic};
    endfunction

    task automatic send(input string tag, input logic [2:0] k, input logic [1:0] c,
                        input logic [1:0] r, input logic [1:0] dd, input logic ds,
                        input logic [3:0] dt, input logic [1:0] td, input logic ts,
                        input logic [3:0] tt, input logic [1:0] io);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; cpl = c; rpl = r; desc_dpl = dd;
        desc_seg = ds; desc_type = dt; tgt_dpl = td; tgt_seg = ts;
        tgt_type = tt; iopl = io;
        exp_q.push_back(expect_of(k, c, r, dd, ds, dt, td, ts, tt, io));
        tag_q.push_back(tag);
        cyc_q.push_back(cyc);
    endtask

    // Monitor: pop and compare each response as it emerges.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            logic [12:0] got;
            got = {rsp_allow, rsp_exc_valid, rsp_exc_num, rsp_new_cpl, rsp_if_clear};
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2 unexpected response got=%h exp=none", got);
            end else begin
                logic [12:0] e;
                string t;
                int    c0;
                e = exp_q.pop_front(); t = tag_q.pop_front(); c0 = cyc_q.pop_front();
                if (got !== e) begin
                    errors++;
                    $display("FAIL %s got=%h exp=%h", t, got, e);
                end
                checks++;
                if (cyc - c0 != STAGES) begin
                    errors++;
                    $display("FAIL R2 latency got=%0d exp=%0d", cyc - c0, STAGES);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++; // R1 outputs quiet during reset
        if ({rsp_valid, rsp_allow, rsp_exc_valid, rsp_exc_num, rsp_new_cpl, rsp_if_clear} !== '0) begin
            errors++;
            $display("FAIL R1 got=%b exp=0", {rsp_valid, rsp_allow, rsp_exc_valid, rsp_if_clear});
        end
        rst = 1'b0;
        @(negedge clk);
        checks++; // R1 first cycle after reset
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 valid after reset got=%b exp=0", rsp_valid);
        end
        // R6 near transfer
        send("R6 near", 3'd0, 2'd3, 2'd3, 2'd0, 1'b1, 4'hA, 2'd0, 1'b0, 4'h0, 2'd0);
        // R3 data loads
        send("R3 data ok",        3'd1, 2'd0, 2'd0, 2'd3, 1'b1, 4'h2, 2'd0, 1'b0, 4'h0, 2'd0);
        send("R3 data dpl low",   3'd1, 2'd2, 2'd0, 2'd1, 1'b1, 4'h2, 2'd0, 1'b0, 4'h0, 2'd0);
        send("R3 data rpl weak",  3'd1, 2'd0, 2'd3, 2'd2, 1'b1, 4'h2, 2'd0, 1'b0, 4'h0, 2'd0);
        send("R3 exec-only code", 3'd1, 2'd0, 2'd0, 2'd3, 1'b1, 4'h8, 2'd0, 1'b0, 4'h0, 2'd0);
        send("R3 readable code",  3'd1, 2'd3, 2'd3, 2'd3, 1'b1, 4'hA, 2'd0, 1'b0, 4'h0, 2'd0);
        send("R3 system desc",    3'd1, 2'd0, 2'd0, 2'd3, 1'b0, 4'h2, 2'd0, 1'b0, 4'h0, 2'd0);
        // R4 I/O
        send("R4 io equal",  3'd4, 2'd1, 2'd0, 2'd0, 1'b0, 4'h0, 2'd0, 1'b0, 4'h0, 2'd1);
        send("R4 io denied", 3'd4, 2'd3, 2'd0, 2'd0, 1'b0, 4'h0, 2'd0, 1'b0, 4'h0, 2'd0);
        // R5 privileged
        send("R5 priv pl0",    3'd5, 2'd0, 2'd0, 2'd0, 1'b0, 4'h0, 2'd0, 1'b0, 4'h0, 2'd0);
        send("R5 priv pl1",    3'd5, 2'd1, 2'd0, 2'd0, 1'b0, 4'h0, 2'd0, 1'b0, 4'h0, 2'd3);
        send("R5 iopl wr pl3", 3'd6, 2'd3, 2'd0, 2'd0, 1'b0, 4'h0, 2'd0, 1'b0, 4'h0, 2'd3);
        send("R5 iopl wr pl0", 3'd6, 2'd0, 2'd0, 2'd0, 1'b0, 4'h0, 2'd0, 1'b0, 4'h0, 2'd0);
        // R7 far direct
        send("R7 nonconf equal", 3'd2, 2'd2, 2'd2, 2'd2, 1'b1, 4'hA, 2'd0, 1'b0, 4'h0, 2'd0);
        send("R7 nonconf inner", 3'd2, 2'd2, 2'd2, 2'd1, 1'b1, 4'hA, 2'd0, 1'b0, 4'h0, 2'd0);
        send("R7 conf inner",    3'd2, 2'd2, 2'd2, 2'd1, 1'b1, 4'hE, 2'd0, 1'b0, 4'h0, 2'd0);
        send("R7 conf outer",    3'd2, 2'd2, 2'd2, 2'd3, 1'b1, 4'hE, 2'd0, 1'b0, 4'h0, 2'd0);
        send("R7 far to data",   3'd2, 2'd2, 2'd2, 2'd2, 1'b1, 4'h2, 2'd0, 1'b0, 4'h0, 2'd0);
        // R8 gate target types
        send("R8 call to data",  3'd3, 2'd3, 2'd3, 2'd3, 1'b0, 4'hC, 2'd0, 1'b1, 4'h2, 2'd0);
        send("R8 task to code",  3'd3, 2'd3, 2'd3, 2'd3, 1'b0, 4'h5, 2'd0, 1'b1, 4'hA, 2'd0);
        send("R8 task to tss",   3'd3, 2'd3, 2'd3, 2'd3, 1'b0, 4'h5, 2'd0, 1'b0, 4'h9, 2'd0);
        send("R8 intr to tss",   3'd3, 2'd3, 2'd3, 2'd3, 1'b0, 4'hE, 2'd0, 1'b0, 4'h9, 2'd0);
        send("R8 not a gate",    3'd3, 2'd3, 2'd3, 2'd3, 1'b0, 4'h2, 2'd0, 1'b1, 4'hA, 2'd0);
        // R9 gate privilege and new level
        send("R9 call inward",    3'd3, 2'd3, 2'd3, 2'd3, 1'b0, 4'hC, 2'd0, 1'b1, 4'hA, 2'd0);
        send("R9 gate dpl low",   3'd3, 2'd3, 2'd3, 2'd0, 1'b0, 4'hC, 2'd0, 1'b1, 4'hA, 2'd0);
        send("R9 target outward", 3'd3, 2'd1, 2'd1, 2'd3, 1'b0, 4'hC, 2'd3, 1'b1, 4'hA, 2'd0);
        send("R9 conf target",    3'd3, 2'd2, 2'd2, 2'd3, 1'b0, 4'h4, 2'd0, 1'b1, 4'hE, 2'd0);
        // R10 interrupt versus trap gate
        send("R10 intr clears", 3'd3, 2'd3, 2'd3, 2'd3, 1'b0, 4'hE, 2'd0, 1'b1, 4'hA, 2'd0);
        send("R10 trap keeps",  3'd3, 2'd3, 2'd3, 2'd3, 1'b0, 4'hF, 2'd0, 1'b1, 4'hA, 2'd0);
        // R11 reserved code
        send("R11 reserved", 3'd7, 2'd0, 2'd0, 2'd0, 1'b1, 4'h2, 2'd0, 1'b0, 4'h0, 2'd3);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (STAGES + 4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2 missing responses got=%0d exp=0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule